// File: doc/BRIEF.md
# Packet-Committing Slave Write FIFO

This block is the write side of a multi-buffer slave FIFO driven by an external master on a shared interface clock. Every rising edge at which the master holds chip select and write strobe high stores one data byte into the buffer chosen by the buffer-select lines. Holding both strobes high for several cycles therefore gives a gap-free burst. Each of the four buffers has its own storage, pointers, byte count and flags. Bytes collect into a packet until the packet is closed.

A packet closes in one of two ways. In automatic mode it closes when the count of stored, still-open bytes reaches a programmed size. Otherwise it closes when the master raises a close strobe. A close strobe counts a byte written on the same edge, and it may also come on any later cycle. Each closed packet pushes a tag, made of the buffer index and the byte length, into a small commit queue. The consumer side sees the head of that queue and pops it. It drains committed bytes through a simple read port, and it can never read bytes that are still uncommitted.

Top module: `slv_pkt_fifo`

## Requirements
- R1: A byte is stored only at a rising edge where `cs` and `wr` are both 1; with either at 0, nothing is stored and the open packet length stays unchanged.
- R2: While `cs` and `wr` stay at 1, one byte is stored on every edge, and bytes are read back from a buffer in the order they were written.
- R3: `empty[b]` is 1 when buffer b holds no bytes and `full[b]` is 1 when it holds DEPTH bytes (16 by default). Both are registered, so they change only after the edge that stores or removes a byte.
- R4: A write to a full buffer is dropped and sets `ovf[b]`. `ovf[b]` stays at 1 until reset.
- R5: When `pkt_close` is 1 on the same edge as an accepted write, the committed packet includes that write's byte.
- R6: `pkt_close` without a write commits every byte stored in the selected buffer since its last commit. With none stored, it commits a zero-length packet.
- R7: With `auto_en` at 1, the edge whose write brings the open byte count to `auto_size` commits a packet of that length. An `auto_size` of 0 never triggers.
- R8: A `pkt_close` on the edge directly after an automatic commit forms a separate packet. With one byte written on that edge its length is 1; with no byte its length is 0.
- R9: `buf_sel` (0 to 3) selects the buffer for writes and closes. The flags, overflow and contents of the other buffers are unaffected.
- R10: Commit tags leave the queue in commit order. The head (`cq_buf`, `cq_len`) holds until `cq_pop`. A commit made while the queue holds QDEPTH tags (4 by default) and is not popped is lost and sets the sticky `cq_ovf`.
- R11: When an automatic length is reached on the same edge as `pkt_close`, exactly one packet is committed.
- R12: `rd_data` shows the oldest byte of buffer `rd_buf`, and `rd_en` removes it. A read is ignored when that buffer has no committed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, active high |
| buf_sel | input | BUF_W | Buffer select for writes and closes |
| din | input | DW | Write data |
| pkt_close | input | 1 | Close the open packet of the selected buffer |
| auto_en | input | 1 | Enable automatic commit |
| auto_size | input | LEN_W | Automatic packet length |
| rd_en | input | 1 | Remove the oldest committed byte of `rd_buf` |
| rd_buf | input | BUF_W | Buffer select for the read port |
| rd_data | output | DW | Oldest byte of `rd_buf` |
| full | output | NBUF | Per-buffer full flag |
| empty | output | NBUF | Per-buffer empty flag |
| ovf | output | NBUF | Per-buffer sticky write overflow |
| cq_valid | output | 1 | Commit queue holds a tag |
| cq_buf | output | BUF_W | Buffer index of the head tag |
| cq_len | output | LEN_W | Byte length of the head tag |
| cq_pop | input | 1 | Remove the head tag |
| cq_ovf | output | 1 | Sticky: a commit tag was lost |

## Verification
Three things can land on the same edge: a byte write, a manual close, and the automatic length being reached. The bench drives a burst whose last byte carries the close strobe. It also drives a run of exactly `auto_size` bytes with the close strobe on the final byte, and it raises the close strobe on the edge directly after an automatic commit, both with and without a byte. The scoreboard queue holds the tags the requirements predict for each case: one packet containing the same-edge byte, and separate packets of length 1 or 0 after an automatic commit. The monitor then compares every tag the design delivers with that queue, in order.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  localparam int unsigned PFW_NBUF   = 4;
  localparam int unsigned PFW_DEPTH  = 16;
  localparam int unsigned PFW_DW     = 8;
  localparam int unsigned PFW_QDEPTH = 4;

  // index width that stays at least one bit
  function automatic int unsigned pfw_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pfw_rst_sync.sv
module pfw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/pfw_buf_ctl.sv
module pfw_buf_ctl #(
  parameter  int unsigned DEPTH = pfw_pkg::PFW_DEPTH,
  parameter  int unsigned DW    = pfw_pkg::PFW_DW,
  localparam int unsigned PW    = pfw_pkg::pfw_w(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          close_req,
  input  logic          auto_en,
  input  logic [CW-1:0] auto_size,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic [DW-1:0] rdata,
  output logic          commit,
  output logic [CW-1:0] commit_len
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d, pend_q, pend_d, pend_w;
  logic          ovf_q, ovf_d;
  logic          full_c, empty_c, wr_ok, rd_ok, auto_hit;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    full_c   = (cnt_q == CW'(DEPTH));
    empty_c  = (cnt_q == '0);
    wr_ok    = wr_req && !full_c;
    // only committed bytes may leave
    rd_ok    = rd_req && (cnt_q != pend_q);
    wp_d     = ptr_inc(wp_q);
    rp_d     = ptr_inc(rp_q);
    cnt_d    = cnt_q + CW'(wr_ok) - CW'(rd_ok);
    pend_w   = pend_q + CW'(wr_ok);
    auto_hit = auto_en && wr_ok && (pend_w == auto_size);
    commit   = close_req || auto_hit;
    commit_len = pend_w;
    pend_d   = commit ? '0 : pend_w;
    ovf_d    = ovf_q || (wr_req && full_c);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ok)           wp_q   <= wp_d;
      if (rd_ok)           rp_q   <= rp_d;
      if (wr_ok || rd_ok)  cnt_q  <= cnt_d;
      if (wr_ok || commit) pend_q <= pend_d;
      ovf_q <= ovf_d;
    end
  end

  assign full  = full_c;
  assign empty = empty_c;
  assign ovf   = ovf_q;
  assign rdata = mem_q[rp_q];
endmodule

// File: rtl/pfw_cq.sv
module pfw_cq #(
  parameter  int unsigned W     = 8,
  parameter  int unsigned DEPTH = pfw_pkg::PFW_QDEPTH,
  localparam int unsigned PW    = pfw_pkg::pfw_w(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         lost
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lost_q, do_pop, do_push;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (do_push)            wp_q   <= ptr_inc(wp_q);
      if (do_pop)             rp_q   <= ptr_inc(rp_q);
      if (do_push || do_pop)  cnt_q  <= cnt_d;
      if (push && !do_push)   lost_q <= 1'b1;
    end
  end

  assign valid = (cnt_q != '0);
  assign dout  = mem_q[rp_q];
  assign lost  = lost_q;
endmodule

// File: rtl/slv_pkt_fifo.sv
module slv_pkt_fifo #(
  parameter  int unsigned NBUF   = pfw_pkg::PFW_NBUF,
  parameter  int unsigned DEPTH  = pfw_pkg::PFW_DEPTH,
  parameter  int unsigned DW     = pfw_pkg::PFW_DW,
  parameter  int unsigned QDEPTH = pfw_pkg::PFW_QDEPTH,
  localparam int unsigned BUF_W  = pfw_pkg::pfw_w(NBUF),
  localparam int unsigned LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             wr,
  input  logic [BUF_W-1:0] buf_sel,
  input  logic [DW-1:0]    din,
  input  logic             pkt_close,
  input  logic             auto_en,
  input  logic [LEN_W-1:0] auto_size,
  input  logic             rd_en,
  input  logic [BUF_W-1:0] rd_buf,
  output logic [DW-1:0]    rd_data,
  output logic [NBUF-1:0]  full,
  output logic [NBUF-1:0]  empty,
  output logic [NBUF-1:0]  ovf,
  output logic             cq_valid,
  output logic [BUF_W-1:0] cq_buf,
  output logic [LEN_W-1:0] cq_len,
  input  logic             cq_pop,
  output logic             cq_ovf
);
  localparam int unsigned TAG_W = BUF_W + LEN_W;

  logic                 rst_sync_n;
  logic                 wr_strobe;
  logic [NBUF-1:0]      commit_v;
  logic [DW-1:0]        rdata_a [NBUF];
  logic [LEN_W-1:0]     clen_a  [NBUF];
  logic [TAG_W-1:0]     tag_in, tag_out;
  logic                 commit_any;

  pfw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign wr_strobe = cs && wr;

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic sel_w, sel_r;
    assign sel_w = (buf_sel == BUF_W'(b));
    assign sel_r = (rd_buf == BUF_W'(b));

    pfw_buf_ctl #(.DEPTH(DEPTH), .DW(DW)) u_buf (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_req     (wr_strobe && sel_w),
      .rd_req     (rd_en && sel_r),
      .close_req  (pkt_close && sel_w),
      .auto_en    (auto_en),
      .auto_size  (auto_size),
      .din        (din),
      .full       (full[b]),
      .empty      (empty[b]),
      .ovf        (ovf[b]),
      .rdata      (rdata_a[b]),
      .commit     (commit_v[b]),
      .commit_len (clen_a[b])
    );
  end

  // only the selected buffer can commit in a cycle
  always_comb begin
    commit_any = |commit_v;
    tag_in     = {buf_sel, clen_a[buf_sel]};
    rd_data    = rdata_a[rd_buf];
  end

  pfw_cq #(.W(TAG_W), .DEPTH(QDEPTH)) u_cq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (commit_any),
    .din   (tag_in),
    .pop   (cq_pop),
    .valid (cq_valid),
    .dout  (tag_out),
    .lost  (cq_ovf)
  );

  assign cq_buf = tag_out[TAG_W-1:LEN_W];
  assign cq_len = tag_out[LEN_W-1:0];
endmodule

// File: rtl/pfw_chk.sv
module pfw_chk #(
  parameter int unsigned NBUF  = 4,
  parameter int unsigned BUF_W = 2,
  parameter int unsigned LEN_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             wr,
  input logic [BUF_W-1:0] buf_sel,
  input logic             pkt_close,
  input logic             rd_en,
  input logic [BUF_W-1:0] rd_buf,
  input logic [NBUF-1:0]  full,
  input logic [NBUF-1:0]  empty,
  input logic [NBUF-1:0]  ovf,
  input logic             cq_valid,
  input logic [BUF_W-1:0] cq_buf,
  input logic [LEN_W-1:0] cq_len,
  input logic             cq_pop,
  input logic             cq_ovf
);
  for (genvar b = 0; b < NBUF; b++) begin : g_b
    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && buf_sel == BUF_W'(b) && !full[b]) |=> !empty[b]); // R3
    AST_FULL_WRITE_OVERFLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && buf_sel == BUF_W'(b) && full[b]) |=> ovf[b]); // R4
    AST_OVF_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[b] |=> ovf[b]); // R4
    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_buf == BUF_W'(b) && empty[b] &&
       !(cs && wr && buf_sel == BUF_W'(b))) |=> empty[b]); // R12
  end

  AST_CLOSE_ENTERS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_close |=> (cq_valid || cq_ovf)); // R6
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cq_valid && !cq_pop) |=> ($stable(cq_buf) && $stable(cq_len) && cq_valid)); // R10
  AST_QUEUE_LOSS_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    cq_ovf |=> cq_ovf); // R10
endmodule

bind slv_pkt_fifo pfw_chk #(.NBUF(NBUF), .BUF_W(BUF_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cs        (cs),
  .wr        (wr),
  .buf_sel   (buf_sel),
  .pkt_close (pkt_close),
  .rd_en     (rd_en),
  .rd_buf    (rd_buf),
  .full      (full),
  .empty     (empty),
  .ovf       (ovf),
  .cq_valid  (cq_valid),
  .cq_buf    (cq_buf),
  .cq_len    (cq_len),
  .cq_pop    (cq_pop),
  .cq_ovf    (cq_ovf)
);

// File: tb/sim_slv_pkt_fifo.sv
module sim_slv_pkt_fifo;
  logic       clk, rst_n, cs, wr, pkt_close, auto_en, rd_en, cq_pop;
  logic [1:0] buf_sel, rd_buf, cq_buf;
  logic [7:0] din, rd_data;
  logic [4:0] auto_size, cq_len;
  logic [3:0] full, empty, ovf;
  logic       cq_valid, cq_ovf;

  int n_chk, n_err;
  int exp_q[$];
  bit mon_en;

  slv_pkt_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .buf_sel(buf_sel), .din(din),
    .pkt_close(pkt_close), .auto_en(auto_en), .auto_size(auto_size),
    .rd_en(rd_en), .rd_buf(rd_buf), .rd_data(rd_data),
    .full(full), .empty(empty), .ovf(ovf),
    .cq_valid(cq_valid), .cq_buf(cq_buf), .cq_len(cq_len),
    .cq_pop(cq_pop), .cq_ovf(cq_ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit c, input bit w, input int b, input int d, input bit pe);
    @(negedge clk);
    cs = c; wr = w; buf_sel = 2'(b); din = 8'(d); pkt_close = pe;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic exp_tag(input int b, input int len);
    exp_q.push_back(b * 256 + len);
  endtask

  task automatic rd_chk(input int b, input int exp, input string req);
    @(negedge clk);
    cs = 0; wr = 0; pkt_close = 0;
    rd_buf = 2'(b); rd_en = 1'b1;
    #1 check(req, "read data", int'(rd_data), exp);
  endtask

  task automatic rd_stop();
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cq_pop = 1'b0;
    if (mon_en && rst_n && cq_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R10 unexpected tag: actual %0d expected none",
                 int'(cq_buf) * 256 + int'(cq_len));
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(cq_buf) * 256 + int'(cq_len) != e) begin
          n_err++;
          $display("FAIL R5/R6/R7/R8/R11 tag: actual buf%0d len%0d expected buf%0d len%0d",
                   cq_buf, cq_len, e / 256, e % 256);
        end
      end
      cq_pop = 1'b1;
    end
  end

  initial begin
    #(20 * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cs = 0; wr = 0; pkt_close = 0; auto_en = 0; auto_size = 0;
    rd_en = 0; buf_sel = 0; rd_buf = 0; din = 0; cq_pop = 0; mon_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // reset state R3
    check("R3", "reset empty", int'(empty), 15);
    check("R3", "reset full", int'(full), 0);
    check("R4", "reset ovf", int'(ovf), 0);
    check("R10", "reset cq_valid", int'(cq_valid), 0);

    // R1: a lone strobe stores nothing; close then gives length 0
    drive(1, 0, 0, 8'h99, 0);
    drive(0, 1, 0, 8'h98, 0);
    idle();
    check("R1", "empty after half strobes", int'(empty[0]), 1);
    exp_tag(0, 0);
    drive(0, 0, 0, 0, 1);
    idle();

    // R2 R3 R5: single write, then burst of three with close on last
    drive(1, 1, 0, 8'h11, 0);
    check("R3", "empty before edge", int'(empty[0]), 1);
    idle();
    check("R3", "empty after edge", int'(empty[0]), 0);
    drive(1, 1, 0, 8'h22, 0);
    drive(1, 1, 0, 8'h33, 0);
    exp_tag(0, 4);
    drive(1, 1, 0, 8'h44, 1);
    idle();
    rd_chk(0, 8'h11, "R2");
    rd_chk(0, 8'h22, "R2");
    rd_chk(0, 8'h33, "R2");
    rd_chk(0, 8'h44, "R2");
    rd_stop();
    idle();
    check("R3", "empty after drain", int'(empty[0]), 1);

    // R12: read on empty, then read on uncommitted byte
    @(negedge clk); rd_buf = 0; rd_en = 1;
    rd_stop();
    check("R12", "empty after empty read", int'(empty[0]), 1);
    drive(1, 1, 0, 8'h5A, 0);
    idle();
    @(negedge clk); rd_buf = 0; rd_en = 1;
    rd_stop();
    check("R12", "uncommitted byte kept", int'(empty[0]), 0);
    exp_tag(0, 1);
    drive(0, 0, 0, 0, 1);
    idle();
    rd_chk(0, 8'h5A, "R12");
    rd_stop();
    idle();
    check("R12", "empty after committed read", int'(empty[0]), 1);

    // R6: late close, then close with nothing open
    drive(1, 1, 1, 8'h61, 0);
    drive(1, 1, 1, 8'h62, 0);
    idle();
    exp_tag(1, 2);
    drive(0, 0, 1, 0, 1);
    exp_tag(1, 0);
    drive(0, 0, 1, 0, 1);
    idle();
    rd_chk(1, 8'h61, "R6");
    rd_chk(1, 8'h62, "R6");
    rd_stop();

    // R7 R8 R11: automatic commit at 3
    auto_en = 1; auto_size = 5'd3;
    drive(1, 1, 2, 8'hA0, 0);
    drive(1, 1, 2, 8'hA1, 0);
    exp_tag(2, 3);
    drive(1, 1, 2, 8'hA2, 0);
    exp_tag(2, 1);
    drive(1, 1, 2, 8'hA3, 1);
    drive(1, 1, 2, 8'hA4, 0);
    drive(1, 1, 2, 8'hA5, 0);
    exp_tag(2, 3);
    drive(1, 1, 2, 8'hA6, 1);
    exp_tag(2, 0);
    drive(0, 0, 2, 0, 1);
    idle();
    auto_en = 0;
    for (int i = 0; i < 7; i++) rd_chk(2, 8'hA0 + i, "R8");
    rd_stop();

    // R4 R9: fill buffer 3, overflow it
    for (int i = 0; i < 16; i++) drive(1, 1, 3, 8'h30 + i, 0);
    idle();
    check("R3", "full after 16", int'(full[3]), 1);
    check("R4", "no ovf yet", int'(ovf[3]), 0);
    drive(1, 1, 3, 8'hEE, 0);
    idle();
    check("R4", "ovf after full write", int'(ovf[3]), 1);
    check("R4", "still full", int'(full[3]), 1);
    check("R9", "other ovf untouched", int'(ovf[2:0]), 0);
    check("R9", "other buffers empty", int'(empty[2:0]), 7);
    exp_tag(3, 16);
    drive(0, 0, 3, 0, 1);
    idle();
    for (int i = 0; i < 16; i++) rd_chk(3, 8'h30 + i, "R4");
    rd_stop();
    idle();
    check("R3", "empty after drain", int'(empty[3]), 1);
    check("R4", "ovf sticky", int'(ovf[3]), 1);

    // R10: fill queue with monitor paused
    repeat (4) idle();
    mon_en = 0;
    for (int i = 0; i < 5; i++) begin
      if (i < 4) exp_tag(i % 4, 0);
      drive(0, 0, i % 4, 0, 1);
    end
    idle();
    check("R10", "queue loss flag", int'(cq_ovf), 1);
    check("R10", "head buffer", int'(cq_buf), 0);
    idle();
    check("R10", "head holds", int'(cq_valid), 1);
    check("R10", "head len", int'(cq_len), 0);
    mon_en = 1;
    repeat (8) idle();
    check("R10", "all tags seen", exp_q.size(), 0);
    check("R10", "queue drained", int'(cq_valid), 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule